// File: doc/BRIEF.md
# Rolling Four-Activate Window Limiter

This block throttles row activates so that no more than four of them land inside any stretch of W consecutive clock cycles, counting activates to all eight banks together. A command scheduler raises an activate request and reads back a same-cycle permission. When the scheduler actually issues the activate, it pulses a commit strobe so that the limiter records it. The window is rolling: it has no fixed alignment, and every run of W cycles obeys the cap.

W is worked out at elaboration from two real-valued parameters: the window time and the clock period, both in ns. The ratio is rounded up to the next whole cycle and held to a floor of four. Each of four countdown timers is armed with W-1 when an activate is recorded. An activate may proceed while at least one timer has run down to zero. A commit made without permission is flagged and leaves no trace in the timers.

Top module: `act_window_limiter`

## Requirements
- R1: The window W equals the window time divided by the clock period, rounded up; with 37.5 ns and 4.0 ns, W is 10, so after four activates in cycles n..n+3 the next is refused in cycle n+9 and granted in cycle n+10.
- R2: Out of reset no activate is on record, and four commits in consecutive cycles are all accepted with act_viol_o low.
- R3: Any W consecutive cycles contain at most four accepted commits, and at most one timer is armed per cycle.
- R4: act_allow_o is high in the same cycle as act_req_i when fewer than four accepted commits fall in the previous W-1 cycles.
- R5: act_allow_o is low in every cycle where act_req_i is low.
- R6: A commit in a cycle where four accepted commits already fall in the previous W-1 cycles raises act_viol_o in that same cycle, and it is not counted toward later windows.
- R7: act_viol_o is low in every cycle without a commit, and in every cycle with a commit while there is room.
- R8: A request without a commit consumes no room; only commits arm a timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_req_i | input | 1 | Scheduler asks to issue an activate this cycle |
| act_commit_i | input | 1 | An activate is issued this cycle (one at most per cycle) |
| act_allow_o | output | 1 | Permission for the requested activate, combinational |
| act_viol_o | output | 1 | Commit made while the window was full |

## Verification
A timer that reloads with the wrong value or stalls shows up at act_allow_o as a grant or a refusal that is off by one or more cycles. This becomes visible at the first request after the fourth accepted commit inside a window. A timer that is lost or never armed lets a fifth activate through within W cycles. A rejected commit that is wrongly recorded delays a later grant, and this appears exactly W cycles after the rejected commit. The bench keeps its own list of accepted commit cycles and compares both outputs against it in every driven cycle, over bursts, spaced patterns and request-only stretches.

// File: rtl/act_win_pkg.sv
package act_win_pkg;

  // Round t_win/t_ck up to whole cycles, never below min_c.
  function automatic int unsigned win_cycles(real t_win, real t_ck, int unsigned min_c);
    real ratio;
    int  n;
    ratio = t_win / t_ck;
    n = int'(ratio);
    if (real'(n) < ratio) n = n + 1;
    if (n < int'(min_c)) n = int'(min_c);
    return int'(n);
  endfunction

endpackage

// File: rtl/act_slot_timer.sv
module act_slot_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          idle_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign idle_o = (cnt_q == '0);

endmodule

// File: rtl/act_slot_pick.sv
module act_slot_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] idle_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  // Lowest-index idle slot wins.
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (idle_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign any_o = |idle_i;

endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter real         T_WINDOW_NS = 37.5,
  parameter real         T_CK_NS     = 4.0,
  parameter int unsigned MAX_ACTS    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_req_i,
  input  logic act_commit_i,
  output logic act_allow_o,
  output logic act_viol_o
);

  localparam int unsigned WIN_CYC = act_win_pkg::win_cycles(T_WINDOW_NS, T_CK_NS, MAX_ACTS);
  localparam int unsigned CW      = $clog2(WIN_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(WIN_CYC - 1);

  logic [MAX_ACTS-1:0] slot_idle;
  logic [MAX_ACTS-1:0] slot_grant;
  logic [MAX_ACTS-1:0] slot_load;
  logic                room;

  act_slot_pick #(.N(MAX_ACTS)) u_pick (
    .idle_i  (slot_idle),
    .grant_o (slot_grant),
    .any_o   (room)
  );

  assign slot_load = act_commit_i ? slot_grant : '0;

  for (genvar g = 0; g < int'(MAX_ACTS); g++) begin : g_slot
    act_slot_timer #(.CW(CW)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (slot_load[g]),
      .load_val_i (RELOAD),
      .idle_o     (slot_idle[g])
    );
  end

  assign act_allow_o = act_req_i & room;
  assign act_viol_o  = act_commit_i & ~room;

endmodule

// File: rtl/act_window_limiter_chk.sv
module act_window_limiter_chk #(
  parameter int unsigned WIN_CYC  = 10,
  parameter int unsigned MAX_ACTS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                act_req_i,
  input logic                act_commit_i,
  input logic                act_allow_o,
  input logic                act_viol_o,
  input logic [MAX_ACTS-1:0] slot_load
);

  logic              acc;
  logic [WIN_CYC-2:0] hist_q;

  assign acc = act_commit_i & ~act_viol_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[WIN_CYC-3:0], acc};
  end

  assert_window_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'($countones(hist_q)) + 32'(acc)) <= MAX_ACTS);

  assert_single_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_load));

  assert_allow_room_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_req_i && (32'($countones(hist_q)) < MAX_ACTS)) |-> act_allow_o);

  assert_no_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_req_i |-> !act_allow_o);

  assert_full_viol_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_commit_i && (32'($countones(hist_q)) >= MAX_ACTS)) |-> act_viol_o);

  assert_viol_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_viol_o |-> act_commit_i);

  assert_load_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slot_load) |-> act_commit_i);

endmodule

bind act_window_limiter act_window_limiter_chk #(
  .WIN_CYC  (WIN_CYC),
  .MAX_ACTS (MAX_ACTS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .act_req_i    (act_req_i),
  .act_commit_i (act_commit_i),
  .act_allow_o  (act_allow_o),
  .act_viol_o   (act_viol_o),
  .slot_load    (slot_load)
);

// File: tb/act_window_limiter_tb.sv
module act_window_limiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W_EXP      = 10;   // ceil(37.5 / 4.0)
  localparam int CAP        = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_req = 1'b0;
  logic act_commit = 1'b0;
  logic act_allow_o;
  logic act_viol_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int acc_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  act_window_limiter #(.T_WINDOW_NS(37.5), .T_CK_NS(4.0), .MAX_ACTS(CAP)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .act_req_i    (act_req),
    .act_commit_i (act_commit),
    .act_allow_o  (act_allow_o),
    .act_viol_o   (act_viol_o)
  );

  function automatic bit model_room();
    int n = 0;
    foreach (acc_q[i]) if (acc_q[i] < cyc && cyc - acc_q[i] <= W_EXP - 1) n++;
    return n < CAP;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic req, input logic com, input string tag);
    bit room;
    @(negedge clk);
    act_req = req;
    act_commit = com;
    #1;
    room = model_room();
    check(act_allow_o, req & room, tag, "allow");
    check(act_viol_o, com & ~room, tag, "viol");
    if (com && room) acc_q.push_back(cyc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    act_req = 1'b0;
    act_commit = 1'b0;
    acc_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, "R5");
  endtask

  task automatic t_reset_state();
    do_reset();
    step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R7");
  endtask

  task automatic t_burst_edge();
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R2");
    for (int i = 4; i < 9; i++) step(1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, "R1");   // n+9: refused
    step(1'b1, 1'b1, "R1");   // n+10: granted
    idle(W_EXP);
  endtask

  task automatic t_spread();
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b1, "R3");
      step(1'b1, 1'b0, "R4");
      step(1'b0, 1'b0, "R5");
    end
    idle(W_EXP);
  endtask

  task automatic t_req_only();
    for (int i = 0; i < 2 * W_EXP; i++) step(1'b1, 1'b0, "R8");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R8");
    idle(W_EXP);
  endtask

  task automatic t_viol_uncounted();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R3");
    for (int i = 4; i < 10; i++) step(1'b1, 1'b1, "R6");
    // accepted again at n+10..n+13 only if rejected commits left no trace
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, "R7");
    idle(W_EXP);
  endtask

  task automatic t_irregular();
    bit pat[20] = '{1,0,0,1,1,0,1,1,1,0,1,1,0,0,1,1,1,1,0,1};
    for (int i = 0; i < 20; i++) step(1'b1, pat[i], "R4");
    for (int i = 0; i < 20; i++) step(pat[i], pat[19 - i], "R3");
    idle(W_EXP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_burst_edge();
    t_spread();
    t_req_only();
    t_viol_uncounted();
    t_irregular();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule